// File: doc/BRIEF.md
# Key-Protected Low-Speed Clock Selector

This block chooses the source of the slow timekeeping clock for an always-on domain. Two sources are available. The first is an internal path, derived from the system clock. It passes through a fixed divide-by-32 stage and then through a programmable divide-by-(P+1) stage. The second is an external crystal, presented as a one-cycle tick input that is already aligned to the system clock. Both paths are modelled as clock-enable pulses. The selected pulse train is registered onto `lsclk_tick`. A gated copy of the same pulse train drives `lsclk_out`.

Software programs the block through a simple synchronous register bus. The bus has an address, a write strobe, write data and registered read data. The source control register guards itself against stray writes: it accepts a write only when the upper half-word carries an unlock key. When the external source is chosen and the external oscillator reports a failure, the block falls back to the internal path automatically. Software can disable that fallback with a bypass bit. Fallback never changes what software reads back from the control register.

Top module: `lsclk_sel`

## Requirements
- R1: A write to address 0x00 whose data bits 31:16 equal 0x16AA updates the control fields. These fields are source select (bit 0), external enable (bit 4) and fallback bypass (bit 15).
- R2: A write to address 0x00 whose bits 31:16 differ from 0x16AA changes nothing. Reads of 0x00 after it return the earlier value.
- R3: With control bit 0 at 0, `src_ext` reads 0 and `lsclk_tick` follows the internal path. With bit 0 at 1 and no fallback in effect, `src_ext` reads 1.
- R4: The internal path produces one tick every 32*(P+1) system clock cycles. P is bits 4:0 of address 0x08, and the higher bits of a write to 0x08 are dropped.
- R5: When the external source is in effect, each `ext_tick` pulse appears on `lsclk_tick` one cycle later, undivided.
- R6: `lsclk_out` equals `lsclk_tick` when bit 0 of address 0x60 is 1, and stays 0 when that bit is 0.
- R7: When bit 15 is 0 and `ext_fail` is 1, the internal path is used even when bit 0 is 1. Reads of 0x00 still return bit 0 as programmed.
- R8: When bit 15 is 1, `ext_fail` has no effect on source selection.
- R9: Bits 31:16 of every read return zero, and so does every unmapped address.
- R10: Reset clears every register: internal source, P=0, gate off. All outputs read 0.
- R11: Read data appears on `reg_rdata` one clock after the address is presented. Unused control bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal oscillator source |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ext_tick | input | 1 | External crystal tick, one cycle wide |
| ext_fail | input | 1 | External oscillator failure indication |
| lsclk_tick | output | 1 | Selected low-speed clock enable |
| lsclk_out | output | 1 | Gated copy of the selected tick |
| src_ext | output | 1 | 1 when the external source is in effect |

## Verification
The bench uses the default parameters: a 32-cycle fixed stage and a 5-bit divider field. Small values of P therefore give periods of only a few hundred cycles. This keeps several full internal periods, and a change of P part-way through a period, inside a short run. A 16-bit key also allows writes that are close to the key, differing in a single bit, to be checked for rejection. A behavioural model in the bench predicts read data, tick, gated output and effective source on every cycle. It does so while the stimulus moves through bad-key writes, fallback with and without the bypass bit, and external pulse trains.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] A_PSC  = 8'h08;
  localparam logic [ADDR_W-1:0] A_GATE = 8'h60;
  localparam int B_SEL   = 0;
  localparam int B_EXTEN = 4;
  localparam int B_NOFB  = 15;
  localparam logic [15:0] UNLOCK = 16'h16AA;

  typedef struct packed {
    logic sel_ext;
    logic ext_en;
    logic no_fb;
  } ctrl_t;
endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
  import lsclk_pkg::*;
#(
  parameter int          PSC_W = 5,
  parameter logic [15:0] KEY   = UNLOCK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic [PSC_W-1:0]  psc,
  output logic              gate
);
  localparam int HALF = DATA_W / 2;

  logic key_ok;
  logic [DATA_W-1:0] rd_mux;

  assign key_ok = (wdata[DATA_W-1:HALF] == KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      psc  <= '0;
      gate <= 1'b0;
    end else if (we) begin
      if (addr == A_CTRL && key_ok) begin
        ctrl.sel_ext <= wdata[B_SEL];
        ctrl.ext_en  <= wdata[B_EXTEN];
        ctrl.no_fb   <= wdata[B_NOFB];
      end
      if (addr == A_PSC)  psc  <= wdata[PSC_W-1:0];
      if (addr == A_GATE) gate <= wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL: begin
        rd_mux[B_SEL]   = ctrl.sel_ext;
        rd_mux[B_EXTEN] = ctrl.ext_en;
        rd_mux[B_NOFB]  = ctrl.no_fb;
      end
      A_PSC:  rd_mux[PSC_W-1:0] = psc;
      A_GATE: rd_mux[0] = gate;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/lsclk_divider.sv
module lsclk_divider #(
  parameter int PRE_DIV = 32,
  parameter int PSC_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PSC_W-1:0] psc,
  output logic             int_tick
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic pre_fire;
  logic [PSC_W-1:0] cnt2;

  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] cnt1;
      always_ff @(posedge clk) begin
        if (rst)           cnt1 <= '0;
        else if (pre_fire) cnt1 <= '0;
        else               cnt1 <= cnt1 + 1'b1;
      end
      assign pre_fire = (cnt1 == PRE_W'(PRE_DIV - 1));
    end else begin : g_nopre
      assign pre_fire = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt2     <= '0;
      int_tick <= 1'b0;
    end else begin
      int_tick <= pre_fire && (cnt2 >= psc);
      if (pre_fire) begin
        if (cnt2 >= psc) cnt2 <= '0;
        else             cnt2 <= cnt2 + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsclk_mux.sv
module lsclk_mux (
  input  logic clk,
  input  logic rst,
  input  logic sel_ext,
  input  logic no_fb,
  input  logic gate,
  input  logic ext_fail,
  input  logic ext_tick,
  input  logic int_tick,
  output logic tick,
  output logic tick_out,
  output logic src_ext
);
  logic use_ext;
  logic pick;

  assign use_ext = sel_ext && !(ext_fail && !no_fb);
  assign pick    = use_ext ? ext_tick : int_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick     <= 1'b0;
      tick_out <= 1'b0;
      src_ext  <= 1'b0;
    end else begin
      tick     <= pick;
      tick_out <= pick && gate;
      src_ext  <= use_ext;
    end
  end
endmodule

// File: rtl/lsclk_sel.sv
module lsclk_sel
  import lsclk_pkg::*;
#(
  parameter int          PRE_DIV = 32,
  parameter int          PSC_W   = 5,
  parameter logic [15:0] KEY     = UNLOCK
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ext_tick,
  input  logic        ext_fail,
  output logic        lsclk_tick,
  output logic        lsclk_out,
  output logic        src_ext
);
  ctrl_t            cfg;
  logic [PSC_W-1:0] cfg_psc;
  logic             cfg_gate;
  logic             int_tick;
  logic             unused_ext_en;

  assign unused_ext_en = cfg.ext_en;

  lsclk_regs #(.PSC_W(PSC_W), .KEY(KEY)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .rdata(reg_rdata), .ctrl(cfg), .psc(cfg_psc), .gate(cfg_gate)
  );

  lsclk_divider #(.PRE_DIV(PRE_DIV), .PSC_W(PSC_W)) u_div (
    .clk(clk), .rst(rst), .psc(cfg_psc), .int_tick(int_tick)
  );

  lsclk_mux u_mux (
    .clk(clk), .rst(rst), .sel_ext(cfg.sel_ext), .no_fb(cfg.no_fb),
    .gate(cfg_gate), .ext_fail(ext_fail), .ext_tick(ext_tick),
    .int_tick(int_tick), .tick(lsclk_tick), .tick_out(lsclk_out),
    .src_ext(src_ext)
  );
endmodule

// File: rtl/lsclk_sel_chk.sv
module lsclk_sel_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  reg_addr,
  input logic        reg_we,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        ext_fail,
  input logic        lsclk_tick,
  input logic        lsclk_out,
  input logic        src_ext,
  input logic        c_sel,
  input logic        c_en,
  input logic        c_nofb,
  input logic        c_gate
);
  AST_BAD_KEY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 8'h00 && reg_wdata[31:16] != 16'h16AA)
      |=> ($stable(c_sel) && $stable(c_en) && $stable(c_nofb))); // R2
  AST_GOOD_KEY_LOAD: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 8'h00 && reg_wdata[31:16] == 16'h16AA)
      |=> (c_sel == $past(reg_wdata[0]) && c_nofb == $past(reg_wdata[15]))); // R1
  AST_INT_WHEN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !c_sel |=> !src_ext); // R3
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    !c_gate |=> !lsclk_out); // R6
  AST_OUT_SUBSET: assert property (@(posedge clk) disable iff (rst)
    lsclk_out |-> lsclk_tick); // R6
  AST_FALLBACK: assert property (@(posedge clk) disable iff (rst)
    (ext_fail && !c_nofb) |=> !src_ext); // R7
  AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (c_sel && c_nofb) |=> src_ext); // R8
  AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[31:16] == 16'h0); // R9
endmodule

bind lsclk_sel lsclk_sel_chk u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_fail(ext_fail),
  .lsclk_tick(lsclk_tick), .lsclk_out(lsclk_out), .src_ext(src_ext),
  .c_sel(cfg.sel_ext), .c_en(cfg.ext_en), .c_nofb(cfg.no_fb),
  .c_gate(cfg_gate)
);

// File: tb/tb_lsclk_sel.sv
module tb_lsclk_sel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ext_tick = 1'b0;
  logic        ext_fail = 1'b0;
  logic        lsclk_tick, lsclk_out, src_ext;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit ext_run = 0;
  string cur_req = "R10";

  // behavioural model state
  bit m_sel, m_en, m_nofb, m_gate, m_int;
  int m_psc, m_c1, m_c2;
  bit e_tick, e_out, e_src;
  logic [31:0] e_rd;

  lsclk_sel dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_tick(ext_tick),
    .ext_fail(ext_fail), .lsclk_tick(lsclk_tick), .lsclk_out(lsclk_out),
    .src_ext(src_ext)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] v = 32'h0;
    if (a == 8'h00) begin
      v[0] = m_sel; v[4] = m_en; v[15] = m_nofb;
    end else if (a == 8'h08) v = 32'(m_psc);
    else if (a == 8'h60) v[0] = m_gate;
    return v;
  endfunction

  always @(posedge clk) begin
    bit use_ext, pre;
    cyc++;
    if (rst) begin
      m_sel = 0; m_en = 0; m_nofb = 0; m_gate = 0; m_int = 0;
      m_psc = 0; m_c1 = 0; m_c2 = 0;
      e_tick = 0; e_out = 0; e_src = 0; e_rd = '0;
    end else begin
      use_ext = m_sel && !(ext_fail && !m_nofb);
      e_tick = use_ext ? ext_tick : m_int;
      e_out  = e_tick && m_gate;
      e_src  = use_ext;
      e_rd   = model_read(reg_addr);
      pre    = (m_c1 == 31);
      m_int  = pre && (m_c2 >= m_psc);
      m_c1   = (m_c1 + 1) % 32;
      if (pre) m_c2 = (m_c2 >= m_psc) ? 0 : m_c2 + 1;
      if (reg_we) begin
        if (reg_addr == 8'h00 && reg_wdata[31:16] == 16'h16AA) begin
          m_sel = reg_wdata[0]; m_en = reg_wdata[4]; m_nofb = reg_wdata[15];
        end
        if (reg_addr == 8'h08) m_psc = int'(reg_wdata[4:0]);
        if (reg_addr == 8'h60) m_gate = reg_wdata[0];
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && cyc > 2) begin
      check(cur_req, "rdata", reg_rdata, e_rd);
      check(cur_req, "tick", 32'(lsclk_tick), 32'(e_tick));
      check(cur_req, "out", 32'(lsclk_out), 32'(e_out));
      check(cur_req, "src", 32'(src_ext), 32'(e_src));
    end
    ext_tick <= ext_run && (cyc % 7 == 0);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    #1 check(req, "read", reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int t0, t1, pulses;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    cur_req = "R10";
    #1 check("R10", "tick after reset", 32'(lsclk_tick), 0);
    check("R10", "src after reset", 32'(src_ext), 0);
    rd(8'h00, 32'h0, "R10");
    rd(8'h08, 32'h0, "R10");
    rd(8'h60, 32'h0, "R10");
    // R9: unmapped address
    cur_req = "R9";
    rd(8'h04, 32'h0, "R9");
    // R2: bad key, close to the key in one bit
    cur_req = "R2";
    wr(8'h00, 32'h16AB_8011);
    rd(8'h00, 32'h0, "R2");
    // R4: divider with P=3, upper write bits dropped
    cur_req = "R4";
    wr(8'h08, 32'hFFFF_FFE3);
    rd(8'h08, 32'h3, "R4");
    @(posedge lsclk_tick); @(negedge clk);
    @(posedge lsclk_tick); @(negedge clk); t0 = cyc;
    @(posedge lsclk_tick); @(negedge clk); t1 = cyc;
    check("R4", "period P=3", 32'(t1 - t0), 32'd128);
    wr(8'h08, 32'h0);
    @(posedge lsclk_tick); @(negedge clk); t0 = cyc;
    @(posedge lsclk_tick); @(negedge clk); t1 = cyc;
    check("R4", "period P=0", 32'(t1 - t0), 32'd32);
    // R1, R11, R3: keyed write selects external
    cur_req = "R1";
    wr(8'h00, 32'h16AA_FFF1);
    rd(8'h00, 32'h0000_8011, "R11");
    wr(8'h00, 32'h16AA_0011);
    rd(8'h00, 32'h0000_0011, "R1");
    cur_req = "R3";
    idle(2);
    #1 check("R3", "src external", 32'(src_ext), 1);
    // R5: external pulses passed undivided
    cur_req = "R5";
    ext_run = 1;
    pulses = 0;
    for (int i = 0; i < 70; i++) begin
      @(negedge clk); #1 if (lsclk_tick) pulses++;
    end
    check("R5", "external pulse count", 32'(pulses), 32'd10);
    // R6: gate
    cur_req = "R6";
    idle(20);
    wr(8'h60, 32'h1);
    rd(8'h60, 32'h1, "R6");
    idle(30);
    wr(8'h60, 32'h0);
    idle(20);
    wr(8'h60, 32'h1);
    // R7: fallback with readback unchanged
    cur_req = "R7";
    ext_fail = 1'b1;
    idle(2);
    #1 check("R7", "src falls back", 32'(src_ext), 0);
    rd(8'h00, 32'h0000_0011, "R7");
    idle(80);
    // R8: bypass keeps external despite failure
    cur_req = "R8";
    wr(8'h00, 32'h16AA_8011);
    idle(2);
    #1 check("R8", "src held external", 32'(src_ext), 1);
    idle(40);
    // R2: bad key cannot clear the source
    cur_req = "R2";
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, 32'h0000_8011, "R2");
    ext_fail = 1'b0;
    ext_run = 0;
    // R3: back to internal
    cur_req = "R3";
    wr(8'h00, 32'h16AA_0000);
    idle(2);
    #1 check("R3", "src internal", 32'(src_ext), 0);
    wr(8'h08, 32'h1);
    idle(200);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule